// File: doc/BRIEF.md
# Stop-Delimited Issue Group Former

This block sits between an instruction fetch path and the execution ports of an in-order core. Instructions arrive as fixed bundles of three slots. Each slot carries a live bit that says whether it holds a real instruction. Each bundle also carries a barrier flag. A run of consecutive bundles whose barrier flag is clear, closed by one bundle whose flag is set, forms one issue group. The compiler promises that no instruction in a group depends on another in the same group, so the block does no dependency checking. It hands out the live instructions of the current group to as many ports as it has, every cycle.

The number of ports is a parameter. The same bundle stream therefore runs on a narrow or a wide build without being re-encoded: a wide build simply drains a group in fewer cycles. Bundles wait in a small queue. Each queued bundle keeps a mask of the instructions not yet accepted. The two oldest queued bundles form the issue window, and the second one joins the window only when the oldest has a clear barrier flag. Each port has its own valid/ready pair, and any presented instruction may be taken independently of the others. A flush input empties the queue and abandons a partly issued group at once.

Top module: `stop_group_issuer`

## Requirements
- R1: A bundle is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high exactly when fewer than `DEPTH` bundles are queued and `flush` is low.
- R2: A slot whose bit in `in_live` is 0 is never presented on any port. Slot s occupies bits `[s*INSN_W +: INSN_W]` of `in_insn`, and live bit s belongs to it.
- R3: Pending instructions are placed on ports in age order: older bundle first, then lower slot first within a bundle. They fill ports from port 0 upward with no gaps, and port p carries bits `[p*INSN_W +: INSN_W]` of `iss_insn`.
- R4: Up to `NPORTS` instructions are presented per cycle. When the oldest queued bundle has its barrier flag clear, instructions of the next queued bundle fill the remaining ports in the same cycle.
- R5: No instruction of a later group is presented while any instruction of an earlier group, up to and including the bundle with the barrier flag set, is still unaccepted.
- R6: Each port is accepted on its own. An instruction whose port sees ready low stays pending and is presented again in a later cycle, moved down to a lower port if an older instruction ahead of it was taken.
- R7: While `flush` is high, `in_ready` and every `iss_valid` bit are low. From the next cycle on, nothing queued before the flush is ever presented.
- R8: After reset, no port is valid and `in_ready` is high.
- R9: A bundle taken into an empty queue is presented in the cycle right after the edge that took it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Discard all queued bundles and the open group |
| in_valid | input | 1 | Bundle offered |
| in_ready | output | 1 | Bundle can be taken |
| in_insn | input | SLOTS*INSN_W | Slot instructions, slot 0 in the low bits |
| in_live | input | SLOTS | Per-slot live bit, 0 marks an empty slot |
| in_stop | input | 1 | Barrier flag: this bundle closes its group |
| iss_valid | output | NPORTS | Per-port instruction presented |
| iss_ready | input | NPORTS | Per-port acceptance |
| iss_insn | output | NPORTS*INSN_W | Per-port instruction, port 0 in the low bits |

## Verification
A corrupted pending mask or read pointer would show up at once at the ports. An instruction would be dropped, repeated or shown out of order the next time the scoreboard compares a port against its ordered queue of expected items. A barrier that leaks would put two group tags side by side in a single cycle of presented ports, so it is caught in the same cycle it happens. Directed cases pin down exact port contents in cycles where the result is fully fixed: cross-bundle fill, holding at a barrier, one port refusing, and the first cycles after a flush. A pseudo-random stream with shifting ready prefixes covers the mix of empty slots, long groups and back-pressure.

// File: rtl/sgi_pkg.sv
`timescale 1ns/1ps
package sgi_pkg;
    parameter int SLOTS  = 3;
    parameter int INSN_W = 16;
    localparam int WIN   = 2 * SLOTS;

    typedef logic [INSN_W-1:0] insn_t;
    typedef insn_t [SLOTS-1:0] slot_vec_t;
    typedef insn_t [WIN-1:0]   win_vec_t;

    typedef struct packed {
        slot_vec_t              insn;
        logic [SLOTS-1:0]       live;
        logic                   stop;
    } bundle_t;
endpackage

// File: rtl/sgi_bundle_fifo.sv
`timescale 1ns/1ps
module sgi_bundle_fifo
    import sgi_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             push,
    input  bundle_t          push_b,
    output logic             full,
    output logic             head_vld,
    output slot_vec_t        head_insn,
    output logic [SLOTS-1:0] head_live,
    output logic             head_stop,
    output logic             next_vld,
    output slot_vec_t        next_insn,
    output logic [SLOTS-1:0] next_live,
    input  logic [SLOTS-1:0] clr_head,
    input  logic [SLOTS-1:0] clr_next
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    bundle_t         mem [DEPTH];
    logic [PW-1:0]   rd_ptr, wr_ptr, nx_ptr;
    logic [CW-1:0]   count;
    logic            pop;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign nx_ptr    = bump(rd_ptr);
    assign full      = (count == CW'(DEPTH));
    assign head_vld  = (count != '0);
    assign next_vld  = (count > CW'(1));
    assign head_insn = mem[rd_ptr].insn;
    assign head_live = mem[rd_ptr].live;
    assign head_stop = mem[rd_ptr].stop;
    assign next_insn = mem[nx_ptr].insn;
    assign next_live = mem[nx_ptr].live;

    // The oldest bundle leaves once its last pending instruction is taken.
    assign pop = head_vld && ((head_live & ~clr_head) == '0);

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (head_vld) mem[rd_ptr].live <= head_live & ~clr_head;
            if (next_vld) mem[nx_ptr].live <= next_live & ~clr_next;
            if (push) begin
                mem[wr_ptr] <= push_b;
                wr_ptr      <= bump(wr_ptr);
            end
            if (pop) rd_ptr <= nx_ptr;
            count <= count + CW'(push) - CW'(pop);
        end
    end
endmodule

// File: rtl/sgi_port_picker.sv
`timescale 1ns/1ps
module sgi_port_picker
    import sgi_pkg::*;
#(
    parameter int NPORTS = 4
) (
    input  logic [WIN-1:0]          cand,
    input  win_vec_t                cand_insn,
    input  logic [NPORTS-1:0]       iss_ready,
    output logic [NPORTS-1:0]       iss_valid,
    output insn_t [NPORTS-1:0]      iss_insn,
    output logic [WIN-1:0]          take
);
    always_comb begin
        int rank;
        rank      = 0;
        iss_valid = '0;
        iss_insn  = '0;
        take      = '0;
        for (int i = 0; i < WIN; i++) begin
            if (cand[i]) begin
                for (int p = 0; p < NPORTS; p++) begin
                    if (rank == p) begin
                        iss_valid[p] = 1'b1;
                        iss_insn[p]  = cand_insn[i];
                        take[i]      = iss_ready[p];
                    end
                end
                rank = rank + 1;
            end
        end
    end
endmodule

// File: rtl/stop_group_issuer.sv
`timescale 1ns/1ps
module stop_group_issuer
    import sgi_pkg::*;
#(
    parameter int NPORTS = 4,
    parameter int DEPTH  = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       flush,
    input  logic                       in_valid,
    output logic                       in_ready,
    input  logic [SLOTS*INSN_W-1:0]    in_insn,
    input  logic [SLOTS-1:0]           in_live,
    input  logic                       in_stop,
    output logic [NPORTS-1:0]          iss_valid,
    input  logic [NPORTS-1:0]          iss_ready,
    output logic [NPORTS*INSN_W-1:0]   iss_insn
);
    bundle_t          push_b;
    logic             full, push;
    logic             head_vld, next_vld, head_stop;
    slot_vec_t        head_insn, next_insn;
    logic [SLOTS-1:0] head_live, next_live;
    logic [WIN-1:0]   cand, take;
    insn_t [NPORTS-1:0] pick_insn;

    assign in_ready    = !full && !flush;
    assign push        = in_valid && in_ready;
    assign push_b.insn = in_insn;
    assign push_b.live = in_live;
    assign push_b.stop = in_stop;

    sgi_bundle_fifo #(.DEPTH(DEPTH)) fifo_i (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush),
        .push      (push),
        .push_b    (push_b),
        .full      (full),
        .head_vld  (head_vld),
        .head_insn (head_insn),
        .head_live (head_live),
        .head_stop (head_stop),
        .next_vld  (next_vld),
        .next_insn (next_insn),
        .next_live (next_live),
        .clr_head  (take[SLOTS-1:0]),
        .clr_next  (take[WIN-1:SLOTS])
    );

    // Window: the oldest bundle, plus the next one only if no barrier closes the oldest.
    always_comb begin
        cand = '0;
        if (!flush) begin
            cand[SLOTS-1:0] = head_live & {SLOTS{head_vld}};
            cand[WIN-1:SLOTS] = next_live & {SLOTS{next_vld && !head_stop}};
        end
    end

    sgi_port_picker #(.NPORTS(NPORTS)) pick_i (
        .cand      (cand),
        .cand_insn ({next_insn, head_insn}),
        .iss_ready (iss_ready),
        .iss_valid (iss_valid),
        .iss_insn  (pick_insn),
        .take      (take)
    );

    assign iss_insn = pick_insn;
endmodule

// File: rtl/sgi_checker.sv
`timescale 1ns/1ps
module sgi_checker #(
    parameter int NPORTS = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              flush,
    input logic              in_ready,
    input logic [NPORTS-1:0] iss_valid
);
    logic [NPORTS-1:0] vplus;
    assign vplus = iss_valid + 1'b1;

    // R3: presented ports form a gap-free run from port 0
    a_r3_ports_contiguous: assert property (@(posedge clk) disable iff (rst)
        (iss_valid & vplus) == '0);

    // R7: quiet while flushing
    a_r7_flush_quiet: assert property (@(posedge clk) disable iff (rst)
        flush |-> (!in_ready && iss_valid == '0));

    // R7: queue is empty the cycle after a flush
    a_r7_flush_empties: assert property (@(posedge clk) disable iff (rst)
        flush |=> (iss_valid == '0));

    // R8: idle right after reset is released
    a_r8_reset_idle: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (iss_valid == '0 && (in_ready || flush)));
endmodule

bind stop_group_issuer sgi_checker #(.NPORTS(NPORTS)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .flush     (flush),
    .in_ready  (in_ready),
    .iss_valid (iss_valid)
);

// File: tb/stop_group_issuer_tb_top.sv
`timescale 1ns/1ps
module stop_group_issuer_tb_top;
    localparam int NP = 4;
    localparam int NS = 3;
    localparam int W  = 16;
    localparam int DP = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic flush = 1'b0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [NS*W-1:0] in_insn = '0;
    logic [NS-1:0] in_live = '0;
    logic in_stop = 1'b0;
    logic [NP-1:0] iss_valid;
    logic [NP-1:0] iss_ready = '0;
    logic [NP*W-1:0] iss_insn;

    always #4 clk = ~clk;

    stop_group_issuer #(.NPORTS(NP), .DEPTH(DP)) dut_i (
        .clk(clk), .rst(rst), .flush(flush),
        .in_valid(in_valid), .in_ready(in_ready), .in_insn(in_insn),
        .in_live(in_live), .in_stop(in_stop),
        .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_insn(iss_insn)
    );

    typedef struct { logic [W-1:0] insn; int grp; } exp_t;
    exp_t exp_q[$];
    int ncmp = 0, nbad = 0, grp = 0;
    logic [W-1:0] next_id = 16'h0100;
    bit mon_en = 0, rdy_auto = 0, done = 0;
    logic [15:0] lfsr = 16'hACE1;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        ncmp++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    function automatic logic [W-1:0] port(input int p);
        return iss_insn[p*W +: W];
    endfunction

    // Driver: offer one bundle, record expected items at the handshake edge.
    task automatic push_bundle(input logic [NS-1:0] live, input logic stop,
                               output logic [W-1:0] base);
        @(negedge clk);
        base     = next_id;
        in_valid = 1'b1;
        in_stop  = stop;
        in_live  = live;
        for (int s = 0; s < NS; s++)
            in_insn[s*W +: W] = live[s] ? next_id + W'(s) : 16'hF000 | (next_id + W'(s));
        next_id = next_id + W'(NS);
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        for (int s = 0; s < NS; s++)
            if (live[s]) exp_q.push_back('{insn: base + W'(s), grp: grp});
        if (stop) grp++;
        #1 in_valid = 1'b0;
    endtask

    task automatic do_flush(input bit check);
        @(negedge clk);
        flush = 1'b1;
        #1;
        if (check) begin
            chk(!in_ready, "R7", "in_ready during flush", 32'(in_ready), 0);
            chk(iss_valid == '0, "R7", "iss_valid during flush", 32'(iss_valid), 0);
        end
        @(posedge clk);
        #1 flush = 1'b0;
        @(negedge clk);
        if (check) chk(iss_valid == '0, "R7", "iss_valid after flush", 32'(iss_valid), 0);
        exp_q.delete();
    endtask

    // Ready driver: random prefix masks in auto mode
    initial forever begin
        @(posedge clk);
        #1;
        if (rdy_auto) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            iss_ready = NP'((1 << (lfsr % (NP + 1))) - 1);
        end
    end

    // Monitor: compare presented ports against the ordered expectation
    initial forever begin
        @(negedge clk);
        if (mon_en && !rst) begin
            int n, k;
            n = 0;
            k = 0;
            for (int p = 0; p < NP; p++) if (iss_valid[p]) n++;
            for (int p = 0; p < n; p++) begin
                if (p >= exp_q.size()) begin
                    chk(0, "R2", "unexpected instruction", 32'(port(p)), 0);
                end else begin
                    chk(port(p) == exp_q[p].insn, "R3", "port order", 32'(port(p)), 32'(exp_q[p].insn));
                    chk(exp_q[p].grp == exp_q[0].grp, "R5", "group mix", 32'(exp_q[p].grp), 32'(exp_q[0].grp));
                    if (iss_ready[p]) k++;
                end
            end
            for (int j = 0; j < k; j++) void'(exp_q.pop_front());
        end
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            nbad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] b0, b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(iss_valid == '0, "R8", "iss_valid after reset", 32'(iss_valid), 0);
        chk(in_ready, "R8", "in_ready after reset", 32'(in_ready), 1);

        // R2 / R9: empty middle slot, first presentation right after the taking edge
        chk(iss_valid == '0, "R9", "idle before push", 32'(iss_valid), 0);
        push_bundle(3'b101, 1'b1, b0);
        @(negedge clk);
        chk(iss_valid == 4'b0011, "R2", "live slots only", 32'(iss_valid), 32'h3);
        chk(port(0) == b0, "R9", "slot0 on port0", 32'(port(0)), 32'(b0));
        chk(port(1) == b0 + 16'd2, "R2", "slot2 on port1", 32'(port(1)), 32'(b0 + 16'd2));

        // R7: flush with three queued bundles, old content gone afterwards
        push_bundle(3'b111, 1'b1, b1);
        push_bundle(3'b111, 1'b1, b1);
        do_flush(1);
        push_bundle(3'b111, 1'b1, b0);
        @(negedge clk);
        chk(port(0) == b0, "R7", "fresh bundle at head", 32'(port(0)), 32'(b0));
        chk(iss_valid == 4'b0111, "R7", "fresh bundle ports", 32'(iss_valid), 32'h7);

        // R6: only port 1 accepts; remaining instructions compact downward
        iss_ready = 4'b0010;
        @(posedge clk);
        #1 iss_ready = '0;
        @(negedge clk);
        chk(iss_valid == 4'b0011, "R6", "two left", 32'(iss_valid), 32'h3);
        chk(port(0) == b0, "R6", "refused stays", 32'(port(0)), 32'(b0));
        chk(port(1) == b0 + 16'd2, "R6", "slot2 moves down", 32'(port(1)), 32'(b0 + 16'd2));
        do_flush(0);

        // R4: group spans two bundles, fills all four ports
        push_bundle(3'b111, 1'b0, b0);
        push_bundle(3'b111, 1'b1, b1);
        @(negedge clk);
        chk(iss_valid == 4'b1111, "R4", "cross-bundle fill", 32'(iss_valid), 32'hF);
        chk(port(3) == b1, "R4", "port3 from next bundle", 32'(port(3)), 32'(b1));
        do_flush(0);

        // R5: barrier holds the next group back until the current one is accepted
        push_bundle(3'b110, 1'b1, b0);
        push_bundle(3'b111, 1'b1, b1);
        @(negedge clk);
        chk(iss_valid == 4'b0011, "R5", "held at barrier", 32'(iss_valid), 32'h3);
        chk(port(0) == b0 + 16'd1, "R5", "first live slot", 32'(port(0)), 32'(b0 + 16'd1));
        iss_ready = 4'b0011;
        @(posedge clk);
        #1 iss_ready = '0;
        @(negedge clk);
        chk(iss_valid == 4'b0111, "R5", "next group released", 32'(iss_valid), 32'h7);
        chk(port(0) == b1, "R5", "next group head", 32'(port(0)), 32'(b1));
        do_flush(0);

        // R1: queue fills to DEPTH, then in_ready drops
        for (int i = 0; i < DP; i++) push_bundle(3'b111, 1'b1, b0);
        @(negedge clk);
        chk(!in_ready, "R1", "full queue refuses", 32'(in_ready), 0);
        do_flush(0);
        @(negedge clk);
        chk(in_ready, "R1", "ready again after drain", 32'(in_ready), 1);

        // Mixed stream under random ready prefixes
        mon_en   = 1;
        rdy_auto = 1;
        for (int i = 0; i < 80; i++) begin
            logic [NS-1:0] lv;
            logic st;
            lv = NS'($urandom % 8);
            st = ($urandom % 3) == 0;
            push_bundle(lv, st, b0);
            if (($urandom % 4) == 0) @(negedge clk);
        end
        for (int t = 0; t < 400 && exp_q.size() != 0; t++) @(negedge clk);
        chk(exp_q.size() == 0, "R3", "stream drained", 32'(exp_q.size()), 0);
        mon_en   = 0;
        rdy_auto = 0;

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
        $finish;
    end
endmodule